// File: doc/BRIEF.md
# Bus-Master DMA Channel Control and Status Unit

This block is the register-level control unit of one bus-master DMA channel in a SCSI host adapter that sits on a PCI bus. Software programs a starting byte count, a starting physical address and a starting descriptor-list address. It then issues a command through a two-bit operation field. A start operation loads the working registers from the starting registers, clears the status flags and raises a DMA-enable level for the data path. An idle operation drops that level. An abort operation sends a one-cycle cancel pulse to the SCSI core. A blast operation is accepted and does nothing.

While a transfer runs, the data path presents chunk requests together with a direction and a length. The unit grants a request only if its direction matches the direction bit of the command. It trims the grant to the bytes left in the working count, then moves the working count down and the working address up by the granted amount. A completion strobe from the SCSI side zeroes the working count and raises the done flag. A mode input chooses how the done, error and abort flags are cleared: either by writing ones to the status register, or as a side effect of reading it.

Top module: `bmdma_channel`

## Requirements
- R1: After reset, register 0 (command), register 3 (working count) and register 5 (status) read 0. Register 4 (working address) reads 0xFFFFFFFF, register 7 (working descriptor address) reads 0xFFFFFFFD, and dmaEnable is low.
- R2: A write to register 0 stores the whole word, and bits 1:0 select the operation. Value 0 (idle) drops dmaEnable from the next cycle. Value 2 (abort) makes abortPulse high for exactly the next cycle. Value 1 (blast) changes neither dmaEnable, nor the status, nor the working registers.
- R3: Value 3 (start) in bits 1:0 of a command write has these effects from the next cycle: register 1 is copied into register 3, register 2 into register 4 and register 6 into register 7; status bits 5:0 are cleared; dmaEnable is raised.
- R4: Registers 1, 2 and 6 read back the last value written to them. Writes to registers 3, 4 and 7 are ignored. regRdData shows the addressed register in the same cycle as the read.
- R5: A chunk request whose chunkToMem equals command bit 7 (1 means device to memory) is granted min(chunkLen, working count). In the next cycle chunkAck is high with that grant on chunkGrantLen. The working count drops by the grant and the working address rises by the grant.
- R6: A chunk request whose chunkToMem differs from command bit 7 gives a chunkReject pulse in the next cycle and leaves the working count and working address unchanged.
- R7: A cmdDone pulse clears the working count and sets status bit 3 (done) from the next cycle.
- R8: With clrOnRead low, a write to register 5 clears each of status bits 1 (error), 2 (abort) and 3 (done) that is written as 1, and leaves the others unchanged.
- R9: With clrOnRead high, writes to register 5 have no effect. A read of register 5 returns the current flags, and bits 1 to 3 are clear from the next cycle.
- R10: Bit 4 of a register 5 read follows coreIrq in the same cycle and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (status read side effect) |
| regAddr | input | 3 | Register index 0..7 |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data of the addressed register, same cycle |
| clrOnRead | input | 1 | 1: status flags clear on read; 0: written ones clear them |
| coreIrq | input | 1 | SCSI core interrupt flag, reflected in status bit 4 |
| chunkReq | input | 1 | Data path chunk transfer request |
| chunkToMem | input | 1 | Chunk direction, 1 = device to memory |
| chunkLen | input | DATA_W | Requested chunk length in bytes |
| chunkAck | output | 1 | Chunk granted (one cycle after request) |
| chunkReject | output | 1 | Chunk refused for direction mismatch |
| chunkGrantLen | output | DATA_W | Granted length, valid with chunkAck |
| cmdDone | input | 1 | Command completion pulse from the SCSI side |
| dmaEnable | output | 1 | DMA enable level to the data path |
| abortPulse | output | 1 | One-cycle request to cancel the current SCSI command |

## Verification
Read data is combinational, so the scoreboard monitor compares regRdData on the falling edge inside the same cycle in which the read strobe is driven. Every register, flag and output changed by a write, a chunk request or a completion pulse is due one clock edge after the request. The bench therefore waits for the edge that samples the request and checks dmaEnable, abortPulse and the chunk response in the following cycle. Register effects are checked by reads issued after that edge. A status read-clear is checked with two reads in a row: the first returns the flags, the second sees them cleared.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int REG_CNT = 8;
  localparam int IDX_W   = $clog2(REG_CNT);
  localparam int ST_W    = 6;

  typedef enum logic [IDX_W-1:0] {
    IDX_CMD        = 3'd0,
    IDX_START_CNT  = 3'd1,
    IDX_START_ADDR = 3'd2,
    IDX_WORK_CNT   = 3'd3,
    IDX_WORK_ADDR  = 3'd4,
    IDX_STATUS     = 3'd5,
    IDX_START_LIST = 3'd6,
    IDX_WORK_LIST  = 3'd7
  } regIdx_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dmaOp_e;

  localparam int ST_DONE     = 3;
  localparam int ST_CORE_IRQ = 4;
  localparam int CMD_DIR_BIT = 7;

  // flags that software may clear: error, abort, done
  localparam logic [ST_W-1:0] CLR_MASK = 6'b00_1110;

  typedef struct packed {
    logic wrCmd;
    logic wrStartCnt;
    logic wrStartAddr;
    logic wrStartList;
    logic wrStatusW1c;
    logic rdStatusClr;
    logic opStart;
    logic opIdle;
    logic opAbort;
    logic chunkTake;
    logic chunkRefuse;
    logic cmdDone;
  } dpStrobe_t;
endpackage

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
(
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [IDX_W-1:0] regAddr,
  input  logic [1:0]       opField,
  input  logic             clrOnRead,
  input  logic             chunkReq,
  input  logic             chunkToMem,
  input  logic             cmdDirToMem,
  input  logic             cmdDone,
  output dpStrobe_t        strobe
);
  dmaOp_e op;
  logic   cmdHit;
  logic   dirMatch;

  assign op       = dmaOp_e'(opField);
  assign cmdHit   = regWrEn && (regAddr == IDX_CMD);
  assign dirMatch = (chunkToMem == cmdDirToMem);

  always_comb begin
    strobe             = '0;
    strobe.wrCmd       = cmdHit;
    strobe.wrStartCnt  = regWrEn && (regAddr == IDX_START_CNT);
    strobe.wrStartAddr = regWrEn && (regAddr == IDX_START_ADDR);
    strobe.wrStartList = regWrEn && (regAddr == IDX_START_LIST);
    strobe.wrStatusW1c = regWrEn && (regAddr == IDX_STATUS) && !clrOnRead;
    strobe.rdStatusClr = regRdEn && (regAddr == IDX_STATUS) && clrOnRead;
    strobe.opStart     = cmdHit && (op == OP_START);
    strobe.opIdle      = cmdHit && (op == OP_IDLE);
    strobe.opAbort     = cmdHit && (op == OP_ABORT);
    strobe.chunkTake   = chunkReq && dirMatch;
    strobe.chunkRefuse = chunkReq && !dirMatch;
    strobe.cmdDone     = cmdDone;
  end
endmodule

// File: rtl/bmdma_datapath.sv
module bmdma_datapath
  import bmdma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdAddr,
  input  logic              coreIrq,
  input  logic [DATA_W-1:0] chunkLen,
  output logic [DATA_W-1:0] rdData,
  output logic              dmaEnable,
  output logic              abortPulse,
  output logic              chunkAck,
  output logic              chunkReject,
  output logic [DATA_W-1:0] chunkGrantLen,
  output logic              cmdDirToMem,
  output logic [DATA_W-1:0] workCnt,
  output logic [DATA_W-1:0] workAddr,
  output logic [ST_W-1:0]   statusBits
);
  localparam logic [DATA_W-1:0] WORK_ADDR_RST = '1;
  localparam logic [DATA_W-1:0] WORK_LIST_RST = ~DATA_W'(2);

  logic [DATA_W-1:0] cmdReg, startCnt, startAddr, startList, workList;
  logic [DATA_W-1:0] grantLen;
  logic [ST_W-1:0]   statusNext;
  logic [DATA_W-1:0] regView [REG_CNT];

  assign cmdDirToMem = cmdReg[CMD_DIR_BIT];
  assign grantLen    = (chunkLen < workCnt) ? chunkLen : workCnt;

  // command and starting registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg    <= '0;
      startCnt  <= '0;
      startAddr <= '0;
      startList <= '0;
    end else begin
      if (strobe.wrCmd)       cmdReg    <= wrData;
      if (strobe.wrStartCnt)  startCnt  <= wrData;
      if (strobe.wrStartAddr) startAddr <= wrData;
      if (strobe.wrStartList) startList <= wrData;
    end
  end

  // working registers: start, then completion, then chunk
  always_ff @(posedge clk) begin
    if (!rstN) begin
      workCnt  <= '0;
      workAddr <= WORK_ADDR_RST;
      workList <= WORK_LIST_RST;
    end else if (strobe.opStart) begin
      workCnt  <= startCnt;
      workAddr <= startAddr;
      workList <= startList;
    end else if (strobe.cmdDone) begin
      workCnt <= '0;
    end else if (strobe.chunkTake) begin
      workCnt  <= workCnt - grantLen;
      workAddr <= workAddr + grantLen;
    end
  end

  // status flags; setting wins over clearing
  always_comb begin
    statusNext = statusBits;
    if (strobe.opStart)     statusNext = '0;
    if (strobe.wrStatusW1c) statusNext = statusNext & ~(wrData[ST_W-1:0] & CLR_MASK);
    if (strobe.rdStatusClr) statusNext = statusNext & ~CLR_MASK;
    if (strobe.cmdDone)     statusNext[ST_DONE] = 1'b1;
    statusNext[ST_CORE_IRQ] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusBits <= '0;
    else       statusBits <= statusNext;
  end

  // control outputs and chunk responses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaEnable     <= 1'b0;
      abortPulse    <= 1'b0;
      chunkAck      <= 1'b0;
      chunkReject   <= 1'b0;
      chunkGrantLen <= '0;
    end else begin
      if (strobe.opStart)     dmaEnable <= 1'b1;
      else if (strobe.opIdle) dmaEnable <= 1'b0;
      abortPulse  <= strobe.opAbort;
      chunkAck    <= strobe.chunkTake;
      chunkReject <= strobe.chunkRefuse;
      if (strobe.chunkTake) chunkGrantLen <= grantLen;
    end
  end

  // read view
  always_comb begin
    regView[IDX_CMD]        = cmdReg;
    regView[IDX_START_CNT]  = startCnt;
    regView[IDX_START_ADDR] = startAddr;
    regView[IDX_WORK_CNT]   = workCnt;
    regView[IDX_WORK_ADDR]  = workAddr;
    regView[IDX_STATUS]     = DATA_W'(statusBits) | (DATA_W'(coreIrq) << ST_CORE_IRQ);
    regView[IDX_START_LIST] = startList;
    regView[IDX_WORK_LIST]  = workList;
  end

  assign rdData = regView[rdAddr];
endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel
  import bmdma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [IDX_W-1:0]  regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              clrOnRead,
  input  logic              coreIrq,
  input  logic              chunkReq,
  input  logic              chunkToMem,
  input  logic [DATA_W-1:0] chunkLen,
  output logic              chunkAck,
  output logic              chunkReject,
  output logic [DATA_W-1:0] chunkGrantLen,
  input  logic              cmdDone,
  output logic              dmaEnable,
  output logic              abortPulse
);
  dpStrobe_t         strobe;
  logic              cmdDirToMem;
  logic [DATA_W-1:0] workCnt;
  logic [DATA_W-1:0] workAddr;
  logic [ST_W-1:0]   statusBits;

  bmdma_ctrl ctrl_i (
    .regWrEn     (regWrEn),
    .regRdEn     (regRdEn),
    .regAddr     (regAddr),
    .opField     (regWrData[1:0]),
    .clrOnRead   (clrOnRead),
    .chunkReq    (chunkReq),
    .chunkToMem  (chunkToMem),
    .cmdDirToMem (cmdDirToMem),
    .cmdDone     (cmdDone),
    .strobe      (strobe)
  );

  bmdma_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wrData        (regWrData),
    .rdAddr        (regAddr),
    .coreIrq       (coreIrq),
    .chunkLen      (chunkLen),
    .rdData        (regRdData),
    .dmaEnable     (dmaEnable),
    .abortPulse    (abortPulse),
    .chunkAck      (chunkAck),
    .chunkReject   (chunkReject),
    .chunkGrantLen (chunkGrantLen),
    .cmdDirToMem   (cmdDirToMem),
    .workCnt       (workCnt),
    .workAddr      (workAddr),
    .statusBits    (statusBits)
  );
endmodule

// File: rtl/bmdma_channel_chk.sv
module bmdma_channel_chk
  import bmdma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [IDX_W-1:0]  regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              chunkReq,
  input logic              chunkToMem,
  input logic              cmdDone,
  input logic              dmaEnable,
  input logic              abortPulse,
  input logic              cmdDirToMem,
  input logic [DATA_W-1:0] workCnt,
  input logic [DATA_W-1:0] workAddr,
  input logic [ST_W-1:0]   statusBits
);
  logic cmdWr, quiet;
  assign cmdWr = regWrEn && (regAddr == IDX_CMD);
  assign quiet = !regWrEn && !cmdDone;

  AST_START_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && regWrData[1:0] == 2'd3) |=> dmaEnable); // R3

  AST_IDLE_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && regWrData[1:0] == 2'd0) |=> !dmaEnable); // R2

  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && regWrData[1:0] == 2'd2) |=> abortPulse); // R2

  AST_ABORT_ONLY_ON_CMD: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> $past(cmdWr && regWrData[1:0] == 2'd2)); // R2

  AST_REJECT_NO_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    (chunkReq && chunkToMem != cmdDirToMem && quiet)
      |=> ($stable(workCnt) && $stable(workAddr))); // R6

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (chunkReq && chunkToMem == cmdDirToMem && quiet)
      |=> (workCnt <= $past(workCnt) &&
           (workAddr - $past(workAddr)) == ($past(workCnt) - workCnt))); // R5

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDone && !cmdWr) |=> (statusBits[ST_DONE] && workCnt == '0)); // R7
endmodule

bind bmdma_channel bmdma_channel_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regWrData   (regWrData),
  .chunkReq    (chunkReq),
  .chunkToMem  (chunkToMem),
  .cmdDone     (cmdDone),
  .dmaEnable   (dmaEnable),
  .abortPulse  (abortPulse),
  .cmdDirToMem (cmdDirToMem),
  .workCnt     (workCnt),
  .workAddr    (workAddr),
  .statusBits  (statusBits)
);

// File: tb/bmdma_channel_tb.sv
module bmdma_channel_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]    regAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic          clrOnRead = 1'b0, coreIrq = 1'b0;
  logic          chunkReq = 1'b0, chunkToMem = 1'b0;
  logic [DW-1:0] chunkLen = '0;
  logic          chunkAck, chunkReject;
  logic [DW-1:0] chunkGrantLen;
  logic          cmdDone = 1'b0;
  logic          dmaEnable, abortPulse;

  int nChecks = 0;
  int nFails  = 0;

  logic [DW-1:0] rdExpQ[$];
  string         rdTagQ[$];
  logic          ckAckQ[$];
  logic [DW-1:0] ckLenQ[$];
  string         ckTagQ[$];

  always #5 clk = ~clk;

  bmdma_channel #(.DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .clrOnRead(clrOnRead), .coreIrq(coreIrq), .chunkReq(chunkReq),
    .chunkToMem(chunkToMem), .chunkLen(chunkLen), .chunkAck(chunkAck),
    .chunkReject(chunkReject), .chunkGrantLen(chunkGrantLen),
    .cmdDone(cmdDone), .dmaEnable(dmaEnable), .abortPulse(abortPulse)
  );

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [DW-1:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [DW-1:0] exp, string tag);
    @(posedge clk); #1;
    rdExpQ.push_back(exp); rdTagQ.push_back(tag);
    regRdEn = 1'b1; regAddr = a;
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic chunk(logic toMem, logic [DW-1:0] len, logic expAck,
                       logic [DW-1:0] expLen, string tag);
    @(posedge clk); #1;
    ckAckQ.push_back(expAck); ckLenQ.push_back(expLen); ckTagQ.push_back(tag);
    chunkReq = 1'b1; chunkToMem = toMem; chunkLen = len;
    @(posedge clk); #1;
    chunkReq = 1'b0;
  endtask

  task automatic done();
    @(posedge clk); #1; cmdDone = 1'b1;
    @(posedge clk); #1; cmdDone = 1'b0;
  endtask

  // read monitor: combinational data compared mid-cycle
  always @(negedge clk) begin
    if (regRdEn) begin
      if (rdExpQ.size() == 0) check("unexpected read", regRdData, '0);
      else check(rdTagQ.pop_front(), regRdData, rdExpQ.pop_front());
    end
  end

  // chunk response monitor: one cycle after the request
  always @(negedge clk) begin
    if (chunkAck || chunkReject) begin
      if (ckAckQ.size() == 0) check("unexpected chunk response", 1, 0);
      else begin
        automatic string t = ckTagQ.pop_front();
        automatic logic ea = ckAckQ.pop_front();
        automatic logic [DW-1:0] el = ckLenQ.pop_front();
        check({t, " ack"}, {31'd0, chunkAck}, {31'd0, ea});
        check({t, " reject"}, {31'd0, chunkReject}, {31'd0, !ea});
        if (ea) check({t, " grant"}, chunkGrantLen, el);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    check("R1 dmaEnable", {31'd0, dmaEnable}, 0);
    rd(0, 32'h0, "R1 command");
    rd(3, 32'h0, "R1 work count");
    rd(4, 32'hFFFF_FFFF, "R1 work addr");
    rd(7, 32'hFFFF_FFFD, "R1 work list");
    rd(5, 32'h0, "R1 status");

    // R4 starting registers and ignored working writes
    wr(1, 32'h100); wr(2, 32'h1000); wr(6, 32'h2000);
    rd(1, 32'h100, "R4 start count");
    rd(2, 32'h1000, "R4 start addr");
    rd(6, 32'h2000, "R4 start list");
    wr(3, 32'h55); wr(4, 32'h66); wr(7, 32'h77);
    rd(3, 32'h0, "R4 work count write ignored");
    rd(4, 32'hFFFF_FFFF, "R4 work addr write ignored");
    rd(7, 32'hFFFF_FFFD, "R4 work list write ignored");

    // R3 start, direction memory to device
    wr(0, 32'h03);
    check("R3 dmaEnable after start", {31'd0, dmaEnable}, 1);
    rd(3, 32'h100, "R3 work count copy");
    rd(4, 32'h1000, "R3 work addr copy");
    rd(7, 32'h2000, "R3 work list copy");
    rd(0, 32'h03, "R2 command stored");

    // R5 / R6 chunks
    chunk(1'b0, 32'h40, 1'b1, 32'h40, "R5 chunk within count");
    rd(3, 32'hC0, "R5 count after chunk");
    rd(4, 32'h1040, "R5 addr after chunk");
    chunk(1'b1, 32'h10, 1'b0, 32'h0, "R6 wrong direction");
    rd(3, 32'hC0, "R6 count unchanged");
    rd(4, 32'h1040, "R6 addr unchanged");
    chunk(1'b0, 32'h200, 1'b1, 32'hC0, "R5 chunk clipped");
    rd(3, 32'h0, "R5 count exhausted");
    rd(4, 32'h1100, "R5 addr after clip");
    chunk(1'b0, 32'h5, 1'b1, 32'h0, "R5 chunk on empty count");

    // R10 live interrupt bit
    @(posedge clk); #1 coreIrq = 1'b1;
    rd(5, 32'h10, "R10 core irq visible");
    @(posedge clk); #1 coreIrq = 1'b0;
    rd(5, 32'h0, "R10 core irq not stored");

    // R7 completion
    wr(0, 32'h03);
    rd(3, 32'h100, "R3 restart count");
    done();
    rd(3, 32'h0, "R7 count cleared");
    rd(5, 32'h08, "R7 done flag");

    // R8 write-one-to-clear
    wr(5, 32'h0000_0031);
    rd(5, 32'h08, "R8 zero in done bit keeps flag");
    wr(5, 32'h08);
    rd(5, 32'h0, "R8 written one clears done");

    // R9 clear on read
    done();
    @(posedge clk); #1 clrOnRead = 1'b1;
    wr(5, 32'h0E);
    rd(5, 32'h08, "R9 write ignored, read returns flag");
    rd(5, 32'h0, "R9 read cleared flag");
    @(posedge clk); #1 clrOnRead = 1'b0;

    // R3 start clears status
    done();
    rd(5, 32'h08, "R9 no clear with mode off");
    wr(0, 32'h03);
    rd(5, 32'h0, "R3 start clears status");

    // R2 blast is a no-op; direction bit 7
    wr(0, 32'h81);
    check("R2 blast keeps dmaEnable", {31'd0, dmaEnable}, 1);
    rd(5, 32'h0, "R2 blast status untouched");
    rd(3, 32'h100, "R2 blast count untouched");
    rd(0, 32'h81, "R2 blast command stored");
    chunk(1'b1, 32'h10, 1'b1, 32'h10, "R5 device to memory chunk");
    rd(3, 32'hF0, "R5 count after read chunk");
    chunk(1'b0, 32'h10, 1'b0, 32'h0, "R6 mismatch with bit7 set");

    // R2 abort pulse and idle
    wr(0, 32'h82);
    check("R2 abort pulse high", {31'd0, abortPulse}, 1);
    @(posedge clk); #1;
    check("R2 abort pulse one cycle", {31'd0, abortPulse}, 0);
    check("R2 abort keeps dmaEnable", {31'd0, dmaEnable}, 1);
    wr(0, 32'h80);
    check("R2 idle drops dmaEnable", {31'd0, dmaEnable}, 0);

    repeat (3) @(posedge clk);
    check("scoreboard drained", DW'(rdExpQ.size() + ckAckQ.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule